// File: doc/BRIEF.md
# Dual-Bank Table-Lookup Complex Multiplier

The block multiplies a stream of signed complex samples by a stored complex coefficient, producing one full-precision complex product per clock. No hardware multiplier is used. Every product comes from precomputed partial-product tables. Each data word is cut into a low and a high segment, and each segment addresses a table that holds segment-times-coefficient values. The block uses three products instead of four: data-real times coefficient-imaginary, data-imaginary times coefficient-real, and half of (data-real + data-imaginary) times (coefficient-real - coefficient-imaginary). It combines them with adders into the real and imaginary results.

The tables come in two banks. A one-bit select chooses which bank feeds the arithmetic. Holding the reload strobe high streams new partial products, one address per clock, into the bank that is not selected. The pipeline keeps producing results from the selected bank, so a system can prepare the next coefficient and then switch banks without losing a sample. The partial products are computed offline and presented on four load ports. The difference table used by the third product is derived inside the block as the load ports are written.

Top module: `cplx_mult_dbank`

## Requirements
- R1: While reset is asserted, and in the first clock after it is released, both result outputs are zero.
- R2: The real output equals Dr*Cr - Di*Ci as an exact 37-bit two's-complement value. Dr and Di are the 18-bit signed data parts. Cr and Ci are the coefficient held in the bank used for that sample.
- R3: The imaginary output equals Dr*Ci + Di*Cr as an exact 37-bit two's-complement value.
- R4: A sample presented before clock edge k shows its result on the outputs after edge k+3 (4 clocks of latency). A new sample is accepted every clock.
- R5: Each table has 512 entries of 24-bit signed values. A low-segment entry at address a holds a*C, with a read as unsigned 0..511. A high-segment entry at address a holds s*C, where s is a read as a signed 9-bit value. A data word's bits [8:0] address the low tables and bits [17:9] address the high tables.
- R6: The clock edge that sees the reload strobe rise writes the four load-port values to address 0. Each further edge with the strobe still high writes the next address, so 512 clocks fill a bank.
- R7: Reload writes reach only the bank not selected by the select input (select 0 means bank 1 is written). Results from the selected bank continue every clock, unchanged, during a reload.
- R8: Dropping the strobe ends the load. Addresses not yet written keep their earlier contents. A later rise restarts the load at address 0.
- R9: After address 511 has been written, a strobe that stays high writes nothing more.
- R10: The bank used for a sample is the select value present in the same clock as that sample. Alternating the select on consecutive samples alternates the coefficient on consecutive results.
- R11: Full-scale data, including both parts at -131072, gives exact results when the coefficient entries fit their 24-bit fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dat_re_i | input | 18 | Data real part, signed |
| dat_im_i | input | 18 | Data imaginary part, signed |
| bank_sel_i | input | 1 | Selects the coefficient bank for the sample on this clock |
| reload_i | input | 1 | Reload strobe, held high for the whole load |
| ld_re_lo_i | input | 24 | Coefficient-real partial product for the low segment |
| ld_re_hi_i | input | 24 | Coefficient-real partial product for the high segment |
| ld_im_lo_i | input | 24 | Coefficient-imaginary partial product for the low segment |
| ld_im_hi_i | input | 24 | Coefficient-imaginary partial product for the high segment |
| res_re_o | output | 37 | Real part of the product, signed |
| res_im_o | output | 37 | Imaginary part of the product, signed |

## Verification
A corrupted table entry, a write that landed at the wrong address, or a write into the active bank shows up only on results whose data segments hit that address. It appears exactly four clocks after such a sample. So the tests pick data whose segments fall on either side of a partial-load boundary, at address 0, at 511, and in the negative half of the high tables. A wrong bank pointer or a skewed select shows up on the very next result when the select alternates per sample. A pipeline misalignment shows as a nonzero output one clock early or late around an isolated sample.

// File: rtl/cmul_pkg.sv
package cmul_pkg;

    // number of lookup tables and the products they form
    localparam int NUM_TAB  = 6;
    localparam int NUM_PROD = 3;

    // table slots; pairs (lo, hi) are joined into one product each
    localparam int T_CI_LO = 0;  // addressed by data real
    localparam int T_CI_HI = 1;
    localparam int T_CR_LO = 2;  // addressed by data imaginary
    localparam int T_CR_HI = 3;
    localparam int T_CD_LO = 4;  // addressed by half the data sum
    localparam int T_CD_HI = 5;

endpackage

// File: rtl/cmul_reload_seq.sv
module cmul_reload_seq #(
    parameter int AW = 9
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          strobe_i,
    output logic          we_o,
    output logic [AW-1:0] waddr_o
);

    localparam logic [AW-1:0] LAST_ADDR = '1;

    typedef struct packed {
        logic          strobe;
        logic          busy;
        logic [AW-1:0] cnt;
    } seq_t;

    seq_t q, d;
    logic start;

    always_comb begin
        d        = q;
        d.strobe = strobe_i;
        start    = strobe_i & ~q.strobe;
        waddr_o  = start ? '0 : q.cnt;
        we_o     = strobe_i & (start | q.busy);
        if (we_o) begin
            d.cnt  = waddr_o + 1'b1;
            d.busy = (waddr_o != LAST_ADDR);
        end else if (!strobe_i) begin
            d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

endmodule

// File: rtl/cmul_pp_table.sv
module cmul_pp_table #(
    parameter int AW = 9,
    parameter int W  = 25
) (
    input  logic          clk_i,
    input  logic          we_i,
    input  logic          wbank_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [W-1:0]  wdata_i,
    input  logic          rbank_i,
    input  logic [AW-1:0] raddr_i,
    output logic [W-1:0]  rdata_o
);

    localparam int WORDS = 1 << (AW + 1);

    // both banks in one array, bank bit on top of the address
    logic [W-1:0] mem [WORDS];

    always_ff @(posedge clk_i) begin
        if (we_i) mem[{wbank_i, waddr_i}] <= wdata_i;
        rdata_o <= mem[{rbank_i, raddr_i}];
    end

endmodule

// File: rtl/cmul_seg_join.sv
module cmul_seg_join #(
    parameter int AW = 9,
    parameter int EW = 25,
    parameter int OW = 37
) (
    input  logic [EW-1:0] lo_i,
    input  logic [EW-1:0] hi_i,
    output logic [OW-1:0] prod_o
);

    localparam int PAD_HI = OW - EW - AW;
    localparam int PAD_LO = OW - EW;

    // high-segment partial product weighs 2^AW
    always_comb begin
        prod_o = {{PAD_HI{hi_i[EW-1]}}, hi_i, {AW{1'b0}}}
               + {{PAD_LO{lo_i[EW-1]}}, lo_i};
    end

endmodule

// File: rtl/cplx_mult_dbank.sv
module cplx_mult_dbank #(
    parameter int DATA_W = 18,
    parameter int PP_W   = 24,
    parameter int RES_W  = 37
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [DATA_W-1:0] dat_re_i,
    input  logic [DATA_W-1:0] dat_im_i,
    input  logic              bank_sel_i,
    input  logic              reload_i,
    input  logic [PP_W-1:0]   ld_re_lo_i,
    input  logic [PP_W-1:0]   ld_re_hi_i,
    input  logic [PP_W-1:0]   ld_im_lo_i,
    input  logic [PP_W-1:0]   ld_im_hi_i,
    output logic [RES_W-1:0]  res_re_o,
    output logic [RES_W-1:0]  res_im_o
);

    import cmul_pkg::*;

    localparam int AW = DATA_W / 2;   // segment width = table address width
    localparam int EW = PP_W + 1;     // stored entry width (room for difference)
    localparam int NT = NUM_TAB;

    typedef struct packed {
        logic [NT-1:0][AW-1:0] addr;
        logic                  sel;
        logic                  half_lsb;
    } s1_t;

    typedef struct packed {
        logic          half_lsb;
        logic [EW-1:0] unit;
    } s2_t;

    typedef struct packed {
        logic [RES_W-1:0] pa;   // Dr*Ci
        logic [RES_W-1:0] pb;   // Di*Cr
        logic [RES_W-1:0] pd;   // (Dr+Di)*(Cr-Ci)
    } s3_t;

    typedef struct packed {
        s1_t                s1;
        s2_t                s2;
        s3_t                s3;
        logic [1:0][EW-1:0] unit;  // 1*(Cr-Ci) per bank
        logic [RES_W-1:0]   re;
        logic [RES_W-1:0]   im;
    } st_t;

    st_t q, d;

    logic                tab_we;
    logic [AW-1:0]       tab_waddr;
    logic                wbank;
    logic [NT-1:0][EW-1:0] wdata;
    logic [EW-1:0]       rdata [NT];
    logic [RES_W-1:0]    prod  [NUM_PROD];
    logic [DATA_W:0]     dsum;
    logic [DATA_W-1:0]   half;
    logic [RES_W-1:0]    unit_ext;
    logic [RES_W-1:0]    full_re;
    logic [RES_W-1:0]    full_im;

    // ---------------- reload address sequencing ----------------
    cmul_reload_seq #(.AW(AW)) u_seq (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .strobe_i(reload_i),
        .we_o    (tab_we),
        .waddr_o (tab_waddr)
    );

    assign wbank = ~bank_sel_i;

    always_comb begin
        wdata[T_CI_LO] = {ld_im_lo_i[PP_W-1], ld_im_lo_i};
        wdata[T_CI_HI] = {ld_im_hi_i[PP_W-1], ld_im_hi_i};
        wdata[T_CR_LO] = {ld_re_lo_i[PP_W-1], ld_re_lo_i};
        wdata[T_CR_HI] = {ld_re_hi_i[PP_W-1], ld_re_hi_i};
        wdata[T_CD_LO] = {ld_re_lo_i[PP_W-1], ld_re_lo_i}
                       - {ld_im_lo_i[PP_W-1], ld_im_lo_i};
        wdata[T_CD_HI] = {ld_re_hi_i[PP_W-1], ld_re_hi_i}
                       - {ld_im_hi_i[PP_W-1], ld_im_hi_i};
    end

    // ---------------- partial-product tables ----------------
    for (genvar k = 0; k < NT; k++) begin : g_tab
        cmul_pp_table #(.AW(AW), .W(EW)) u_tab (
            .clk_i  (clk_i),
            .we_i   (tab_we),
            .wbank_i(wbank),
            .waddr_i(tab_waddr),
            .wdata_i(wdata[k]),
            .rbank_i(q.s1.sel),
            .raddr_i(q.s1.addr[k]),
            .rdata_o(rdata[k])
        );
    end

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_join
        cmul_seg_join #(.AW(AW), .EW(EW), .OW(RES_W)) u_join (
            .lo_i  (rdata[2*p]),
            .hi_i  (rdata[2*p+1]),
            .prod_o(prod[p])
        );
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        d = q;

        // stage 1: segment addresses, bank, odd bit of the sum
        dsum = {dat_re_i[DATA_W-1], dat_re_i} + {dat_im_i[DATA_W-1], dat_im_i};
        half = dsum[DATA_W:1];
        d.s1.addr[T_CI_LO] = dat_re_i[AW-1:0];
        d.s1.addr[T_CI_HI] = dat_re_i[DATA_W-1:AW];
        d.s1.addr[T_CR_LO] = dat_im_i[AW-1:0];
        d.s1.addr[T_CR_HI] = dat_im_i[DATA_W-1:AW];
        d.s1.addr[T_CD_LO] = half[AW-1:0];
        d.s1.addr[T_CD_HI] = half[DATA_W-1:AW];
        d.s1.sel           = bank_sel_i;
        d.s1.half_lsb      = dsum[0];

        // stage 2: tables read (registered inside), unit term follows
        d.s2.half_lsb = q.s1.half_lsb;
        d.s2.unit     = q.unit[q.s1.sel];

        // stage 3: three products
        unit_ext = {{(RES_W-EW){q.s2.unit[EW-1]}}, q.s2.unit};
        d.s3.pa  = prod[0];
        d.s3.pb  = prod[1];
        d.s3.pd  = (prod[2] << 1) + (q.s2.half_lsb ? unit_ext : '0);

        // stage 4: final sums
        full_re = q.s3.pd + (q.s3.pa - q.s3.pb);
        full_im = q.s3.pa + q.s3.pb;
        d.re    = full_re;
        d.im    = full_im;

        // keep 1*(Cr-Ci) of each bank as it streams past address 1
        if (tab_we && (tab_waddr == AW'(1))) d.unit[wbank] = wdata[T_CD_LO];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign res_re_o = q.re;
    assign res_im_o = q.im;

endmodule

// File: rtl/cmul_chk.sv
module cmul_chk #(
    parameter int AW    = 9,
    parameter int RES_W = 37
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             strobe_i,
    input logic             we_i,
    input logic [AW-1:0]    waddr_i,
    input logic [RES_W-1:0] res_re_i,
    input logic [RES_W-1:0] res_im_i
);

    localparam logic [AW-1:0] LAST_ADDR = '1;

    // R1
    reset_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> (res_re_i == '0 && res_im_i == '0));

    // R6
    load_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(strobe_i) |-> (we_i && waddr_i == '0));

    // R6
    load_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i != LAST_ADDR)
        |=> (!strobe_i || (we_i && waddr_i == $past(waddr_i) + 1'b1)));

    // R8
    idle_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !strobe_i |-> !we_i);

    // R9
    full_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && waddr_i == LAST_ADDR) |=> !we_i);

endmodule

bind cplx_mult_dbank cmul_chk #(.AW(AW), .RES_W(RES_W)) u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(reload_i),
    .we_i    (tab_we),
    .waddr_i (tab_waddr),
    .res_re_i(res_re_o),
    .res_im_i(res_im_o)
);

// File: tb/sim_cplx_mult_dbank.sv
`timescale 1ns/1ps
module sim_cplx_mult_dbank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [17:0] dre, dim;
    logic        sel, rld;
    logic [23:0] l_rl, l_rh, l_il, l_ih;
    logic [36:0] rre, rim;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int bank_cr[2];
    int bank_ci[2];
    int sdr[16];
    int sdi[16];
    bit ssel[16];

    always #2 clk = ~clk;

    cplx_mult_dbank u0 (
        .clk_i(clk), .rst_ni(rst_n), .dat_re_i(dre), .dat_im_i(dim),
        .bank_sel_i(sel), .reload_i(rld),
        .ld_re_lo_i(l_rl), .ld_re_hi_i(l_rh), .ld_im_lo_i(l_il), .ld_im_hi_i(l_ih),
        .res_re_o(rre), .res_im_o(rim)
    );

    // entry format of R5
    function automatic logic [23:0] ent(int a, int c, bit hi);
        int s;
        s = (hi && a >= 256) ? a - 512 : a;
        return 24'(s * c);
    endfunction

    function automatic logic [36:0] want_re(int dr, int di, int cr, int ci);
        longint v;
        v = longint'(dr) * longint'(cr) - longint'(di) * longint'(ci);
        return v[36:0];
    endfunction

    function automatic logic [36:0] want_im(int dr, int di, int cr, int ci);
        longint v;
        v = longint'(dr) * longint'(ci) + longint'(di) * longint'(cr);
        return v[36:0];
    endfunction

    task automatic chk(string req, string what, logic [36:0] act, logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_bank(int cr, int ci, int ncyc);
        for (int n = 0; n < ncyc; n++) begin
            @(negedge clk);
            rld = 1'b1;
            if (n < 512) begin
                l_rl = ent(n, cr, 1'b0); l_rh = ent(n, cr, 1'b1);
                l_il = ent(n, ci, 1'b0); l_ih = ent(n, ci, 1'b1);
            end else begin
                l_rl = 24'hA5A5A5; l_rh = 24'h5A5A5A;
                l_il = 24'h3C3C3C; l_ih = 24'hC3C3C3;
            end
        end
        @(negedge clk);
        rld = 1'b0;
    endtask

    // streams sdr/sdi/ssel back to back, checks each result 4 clocks later
    task automatic stream(int n, string rq_re, string rq_im);
        for (int i = 0; i < n + 4; i++) begin
            @(negedge clk);
            if (i >= 4) begin
                int j = i - 4;
                chk(rq_re, "stream re", rre,
                    want_re(sdr[j], sdi[j], bank_cr[ssel[j]], bank_ci[ssel[j]]));
                chk(rq_im, "stream im", rim,
                    want_im(sdr[j], sdi[j], bank_cr[ssel[j]], bank_ci[ssel[j]]));
            end
            if (i < n) begin
                dre = 18'(sdr[i]); dim = 18'(sdi[i]); sel = ssel[i];
            end else begin
                dre = '0; dim = '0;
            end
        end
    endtask

    task automatic one_shot(int dr, int di, bit s, int cr, int ci, string req);
        @(negedge clk);
        dre = 18'(dr); dim = 18'(di); sel = s;
        @(negedge clk);
        dre = '0; dim = '0;
        repeat (3) @(negedge clk);
        chk(req, "single re", rre, want_re(dr, di, cr, ci));
        chk(req, "single im", rim, want_im(dr, di, cr, ci));
    endtask

    task automatic t_reset;
        rst_n = 1'b0; rld = 1'b0; sel = 1'b0;
        dre = 18'd5; dim = 18'd7;
        l_rl = '0; l_rh = '0; l_il = '0; l_ih = '0;
        repeat (3) @(negedge clk);
        chk("R1", "in reset re", rre, '0);
        chk("R1", "in reset im", rim, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "after release re", rre, '0);
        chk("R1", "after release im", rim, '0);
        dre = '0; dim = '0;
    endtask

    task automatic t_setup;
        // sel 0 -> bank 1 is written (R7), then the reverse
        sel = 1'b0;
        load_bank(12345, -6789, 512);
        bank_cr[1] = 12345; bank_ci[1] = -6789;
        sel = 1'b1;
        load_bank(-16000, 15999, 512);
        bank_cr[0] = -16000; bank_ci[0] = 15999;
    endtask

    // R2 R3 R5 R6 R11: varied and full-scale data on both banks
    task automatic t_basic;
        int pr[8] = '{1000, 0, -1, 131071, -131072, 131071, 511, -77777};
        int pi[8] = '{-2000, 1, 0, 131071, -131072, -131072, -512, 33333};
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < 8; i++) begin
                sdr[i] = pr[i]; sdi[i] = pi[i]; ssel[i] = b[0];
            end
            stream(8, "R2/R5/R11", "R3/R6/R11");
        end
    endtask

    // R4: isolated sample appears exactly on the fourth clock
    task automatic t_latency;
        sel = 1'b1; dre = '0; dim = '0;
        repeat (6) @(negedge clk);
        dre = 18'(4321); dim = 18'(-999);
        @(negedge clk);
        dre = '0; dim = '0;
        @(negedge clk);
        @(negedge clk);
        chk("R4", "one clock early", rre, '0);
        @(negedge clk);
        chk("R4", "on time re", rre, want_re(4321, -999, bank_cr[1], bank_ci[1]));
        chk("R4", "on time im", rim, want_im(4321, -999, bank_cr[1], bank_ci[1]));
        @(negedge clk);
        chk("R4", "one clock late", rre, '0);
    endtask

    // R10: select alternates sample by sample
    task automatic t_toggle;
        for (int i = 0; i < 12; i++) begin
            sdr[i] = 1000 * i - 5000; sdi[i] = 7777 - 1500 * i; ssel[i] = i[0];
        end
        stream(12, "R10", "R10");
    endtask

    // R7: reload bank 1 while bank 0 keeps streaming
    task automatic t_live;
        for (int i = 0; i < 16; i++) begin
            sdr[i] = 3001 * i - 20000; sdi[i] = 45000 - 4099 * i; ssel[i] = 1'b0;
        end
        fork
            load_bank(-321, 9876, 512);
            begin
                repeat (3) stream(16, "R7", "R7");
            end
        join
        bank_cr[1] = -321; bank_ci[1] = 9876;
        one_shot(-60000, 70001, 1'b1, -321, 9876, "R7");
        one_shot(-60000, 70001, 1'b0, -16000, 15999, "R7");
    endtask

    // R8: partial load keeps untouched entries, restart begins at 0
    task automatic t_partial;
        sel = 1'b0;
        load_bank(7, -16384, 100);
        one_shot(1546, 542, 1'b1, 7, -16384, "R8");
        one_shot(102700, 77000, 1'b1, -321, 9876, "R8");
        sel = 1'b0;
        load_bank(7, -16384, 512);
        bank_cr[1] = 7; bank_ci[1] = -16384;
        one_shot(102700, 77000, 1'b1, 7, -16384, "R8");
    endtask

    // R9: strobe held past the last address writes nothing more
    task automatic t_overrun;
        sel = 1'b0;
        load_bank(16383, -16383, 600);
        bank_cr[1] = 16383; bank_ci[1] = -16383;
        one_shot(1546, 542, 1'b1, 16383, -16383, "R9");
        one_shot(1, 0, 1'b1, 16383, -16383, "R9");
        one_shot(102700, 77000, 1'b1, 16383, -16383, "R9");
        one_shot(-5000, 12345, 1'b1, 16383, -16383, "R9");
    endtask

    initial begin
        t_reset();
        t_setup();
        t_basic();
        t_latency();
        t_toggle();
        t_live();
        t_partial();
        t_overrun();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule